// File: doc/BRIEF.md
# Virtual Channel and Switch Allocator

This block is the control half of a wormhole router that carries several virtual channels (VCs) on each physical link. It decides which packet may claim which downstream VC, and which flit may cross the crossbar in each cycle. Allocation works in two separate stages. The first stage runs once per packet: a head flit arrives with its output port already computed, and its input VC claims one free VC on that output port. The second stage runs once per flit: every input VC that owns an output VC competes for the physical output port, and a flit is sent only if the downstream buffer has room for it. Extra VCs cost only buffer state and arbitration. They add no links and no crossbar ports.

Each input VC is managed by a small state machine with the states `IVC_IDLE`, `IVC_VCREQ` and `IVC_ACTIVE`. It has three transitions. *Head accept* (`IVC_IDLE`→`IVC_VCREQ`) happens when a valid head flit is present, and captures the route. *VC win* (`IVC_VCREQ`→`IVC_ACTIVE`) happens when the first stage grants the requested output VC. *Tail send* (`IVC_ACTIVE`→`IVC_IDLE`) happens when the tail flit is granted the switch, and frees the output VC. In every other case the state holds.

To keep wrap-around rings free of deadlock, a packet whose next hop crosses the wrap-around link is bumped to the next VC level. Every other packet keeps its level. Because of this, channel dependences can never close a cycle. Credit counters, one per output VC, track free downstream buffer slots.

Top module: `vcsw_alloc`

## Requirements
- R1: After reset every input VC is idle and every output VC is free. Every credit counter holds CREDITS, and `in_pop` and `out_valid` are all zero.
- R2: Input VC i has level i mod NVC, and channel index c = port*NVC + level. The output VC it requests is `in_route*NVC + L`. L equals the input level, or the input level plus one when `in_wrap` is set on the head flit. The bump saturates at level NVC-1. `out_vc` reports L.
- R3: An output VC is granted only while it is free. It then stays owned by that one input VC until the tail flit of the packet is sent, and it is free from the next cycle on. The flits of two packets never interleave on one output VC.
- R4: A head flit seen at an idle input VC in cycle t causes a VC request in cycle t+1. Requests for one output VC are served round-robin over input VC index. The pointer moves to one past the winner.
- R5: An input VC requests the switch only in the `IVC_ACTIVE` state, while `in_valid` is high and its output VC has a nonzero credit count. The earliest switch grant comes one cycle after the VC grant.
- R6: Switch allocation is input-first. Each input port picks one of its requesting VCs round-robin. Each output port then picks one of the input ports round-robin. At most one flit leaves each input port and each output port per cycle.
- R7: The output-stage pointer advances past each winner. The input-stage pointer of a port advances past its chosen VC only when that choice also wins an output port.
- R8: A credit counter decrements when a flit is sent on its output VC. It increments on a `credit_ret` pulse, and stays unchanged when both happen in the same cycle. It never exceeds CREDITS.
- R9: In the cycle of a grant, `in_pop` marks the granted input VC. For each output port, `out_valid`, `out_src_port`, `out_src_vc` and `out_vc` describe the flit crossing, and they are zero when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NPORT*NVC | A flit is at the front of the input VC buffer |
| in_head | input | NPORT*NVC | Front flit is a head flit |
| in_tail | input | NPORT*NVC | Front flit is a tail flit |
| in_route | input | NPORT*NVC*PW | Output port for the head flit |
| in_wrap | input | NPORT*NVC | Next hop of the head flit crosses the wrap-around link |
| credit_ret | input | NPORT*NVC | One returned credit per output VC (index port*NVC+level) |
| in_pop | output | NPORT*NVC | Front flit of this input VC is sent this cycle |
| out_valid | output | NPORT | Output port carries a flit this cycle |
| out_src_port | output | NPORT*PW | Input port that drives the output port |
| out_src_vc | output | NPORT*VW | Input VC level that drives the output port |
| out_vc | output | NPORT*VW | Downstream VC level of the flit |

## Verification
The bench builds the block with its defaults: three ports, two VC levels and four credits. With two levels, wrapped packets are bumped from level 0 to level 1, and wrapped packets that already sit on level 1 exercise the saturation. With three ports, the round-robin pointers wrap at a count that is not a power of two. A phase with no credit returns drains the four-credit counters to zero, so switch requests are held back and then resume. Random packet lengths from one to four flits, with both single-flit packets and gaps, create contention for the same output VC and the same output port.

// File: rtl/vcsw_pkg.sv
package vcsw_pkg;

    typedef enum logic [1:0] {
        IVC_IDLE,
        IVC_VCREQ,
        IVC_ACTIVE
    } ivc_state_e;

    function automatic int wbits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/vcsw_rr_arb.sv
module vcsw_rr_arb
    import vcsw_pkg::*;
#(
    parameter int N = 2,
    localparam int IW = wbits(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         adv,
    output logic [N-1:0] gnt,
    output logic         any
);

    logic [IW-1:0]  ptr_q;
    logic [IW-1:0]  win;
    logic [2*N-1:0] dbl;
    logic           found;

    // Rotate requests so that the pointer position is examined first.
    always_comb begin
        dbl   = {req, req} >> ptr_q;
        found = 1'b0;
        win   = '0;
        for (int j = 0; j < N; j++) begin
            if (!found && dbl[j]) begin
                found = 1'b1;
                win   = IW'((int'(ptr_q) + j) % N);
            end
        end
        gnt = found ? (N'(1) << win) : '0;
    end

    assign any = found;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv && found) begin
            ptr_q <= (int'(win) == N - 1) ? '0 : win + 1'b1;
        end
    end

endmodule

// File: rtl/vcsw_ivc_ctrl.sv
module vcsw_ivc_ctrl
    import vcsw_pkg::*;
#(
    parameter int NPORT = 3,
    parameter int NVC   = 2,
    parameter int LVL   = 0,
    localparam int PW = wbits(NPORT),
    localparam int VW = wbits(NVC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flit_valid,
    input  logic          flit_head,
    input  logic          flit_tail,
    input  logic [PW-1:0] route,
    input  logic          wrap,
    input  logic          vc_gnt,
    input  logic          sw_gnt,
    output logic          vc_req,
    output logic          active,
    output logic [PW-1:0] tgt_port,
    output logic [VW-1:0] tgt_lvl
);

    localparam bit CAN_BUMP = (LVL < NVC - 1);

    ivc_state_e    st_q, st_d;
    logic [PW-1:0] port_q;
    logic [VW-1:0] lvl_q;
    logic [VW-1:0] lvl_new;
    logic          accept;

    assign accept  = flit_valid && flit_head;
    assign lvl_new = (wrap && CAN_BUMP) ? VW'(LVL + 1) : VW'(LVL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= IVC_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IVC_IDLE:   if (accept)                st_d = IVC_VCREQ;
            IVC_VCREQ:  if (vc_gnt)                st_d = IVC_ACTIVE;
            IVC_ACTIVE: if (sw_gnt && flit_tail)   st_d = IVC_IDLE;
            default:                               st_d = IVC_IDLE;
        endcase
    end

    // Route and dateline level are captured on head accept.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
            lvl_q  <= '0;
        end else if (st_q == IVC_IDLE && accept) begin
            port_q <= route;
            lvl_q  <= lvl_new;
        end
    end

    always_comb begin
        vc_req   = (st_q == IVC_VCREQ);
        active   = (st_q == IVC_ACTIVE);
        tgt_port = port_q;
        tgt_lvl  = lvl_q;
    end

endmodule

// File: rtl/vcsw_vc_alloc.sv
module vcsw_vc_alloc
    import vcsw_pkg::*;
#(
    parameter int NCH = 6,
    localparam int OW = wbits(NCH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         vc_req,
    input  logic [NCH-1:0][OW-1:0] req_ovc,
    input  logic [NCH-1:0]         release_ovc,
    output logic [NCH-1:0]         vc_gnt,
    output logic [NCH-1:0]         busy
);

    logic [NCH-1:0]          busy_q;
    logic [NCH-1:0]          took;
    logic [NCH-1:0][NCH-1:0] g;

    for (genvar o = 0; o < NCH; o++) begin : g_ovc
        logic [NCH-1:0] r;
        always_comb begin
            for (int i = 0; i < NCH; i++) begin
                r[i] = vc_req[i] && (req_ovc[i] == OW'(o)) && !busy_q[o];
            end
        end
        vcsw_rr_arb #(.N(NCH)) arb_i (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (r),
            .adv  (1'b1),
            .gnt  (g[o]),
            .any  (took[o])
        );
    end

    always_comb begin
        vc_gnt = '0;
        for (int o = 0; o < NCH; o++) begin
            vc_gnt = vc_gnt | g[o];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            for (int o = 0; o < NCH; o++) begin
                if (release_ovc[o]) begin
                    busy_q[o] <= 1'b0;
                end else if (took[o]) begin
                    busy_q[o] <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;

endmodule

// File: rtl/vcsw_sw_alloc.sv
module vcsw_sw_alloc
    import vcsw_pkg::*;
#(
    parameter int NPORT = 3,
    parameter int NVC   = 2,
    localparam int NCH = NPORT * NVC,
    localparam int PW  = wbits(NPORT),
    localparam int VW  = wbits(NVC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         sreq,
    input  logic [NCH-1:0][PW-1:0] req_port,
    input  logic [NCH-1:0][VW-1:0] req_lvl,
    output logic [NCH-1:0]         sw_gnt,
    output logic [NPORT-1:0]       out_valid,
    output logic [NPORT*PW-1:0]    out_src_port,
    output logic [NPORT*VW-1:0]    out_src_vc,
    output logic [NPORT*VW-1:0]    out_vc
);

    logic [NPORT-1:0][NVC-1:0]   g1;
    logic [NPORT-1:0]            any1;
    logic [NPORT-1:0]            won;
    logic [NPORT-1:0][VW-1:0]    sel_vc;
    logic [NPORT-1:0][PW-1:0]    sel_port;
    logic [NPORT-1:0][VW-1:0]    sel_lvl;
    logic [NPORT-1:0][NPORT-1:0] req2;
    logic [NPORT-1:0][NPORT-1:0] g2;

    for (genvar p = 0; p < NPORT; p++) begin : g_inport
        vcsw_rr_arb #(.N(NVC)) arb_i (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (sreq[p*NVC +: NVC]),
            .adv  (won[p]),
            .gnt  (g1[p]),
            .any  (any1[p])
        );
    end

    // Decode each input port's choice and form the output-stage requests.
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            sel_vc[p]   = '0;
            sel_port[p] = '0;
            sel_lvl[p]  = '0;
            for (int v = 0; v < NVC; v++) begin
                if (g1[p][v]) begin
                    sel_vc[p]   = VW'(v);
                    sel_port[p] = req_port[p*NVC + v];
                    sel_lvl[p]  = req_lvl[p*NVC + v];
                end
            end
        end
        for (int q = 0; q < NPORT; q++) begin
            for (int p = 0; p < NPORT; p++) begin
                req2[q][p] = any1[p] && (sel_port[p] == PW'(q));
            end
        end
    end

    for (genvar q = 0; q < NPORT; q++) begin : g_outport
        vcsw_rr_arb #(.N(NPORT)) arb_i (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (req2[q]),
            .adv  (1'b1),
            .gnt  (g2[q]),
            .any  (out_valid[q])
        );
    end

    always_comb begin
        won          = '0;
        out_src_port = '0;
        out_src_vc   = '0;
        out_vc       = '0;
        for (int q = 0; q < NPORT; q++) begin
            for (int p = 0; p < NPORT; p++) begin
                if (g2[q][p]) begin
                    won[p]                  = 1'b1;
                    out_src_port[q*PW +: PW] = PW'(p);
                    out_src_vc[q*VW +: VW]   = sel_vc[p];
                    out_vc[q*VW +: VW]       = sel_lvl[p];
                end
            end
        end
        for (int p = 0; p < NPORT; p++) begin
            for (int v = 0; v < NVC; v++) begin
                sw_gnt[p*NVC + v] = won[p] && g1[p][v];
            end
        end
    end

endmodule

// File: rtl/vcsw_alloc.sv
module vcsw_alloc
    import vcsw_pkg::*;
#(
    parameter int NPORT   = 3,
    parameter int NVC     = 2,
    parameter int CREDITS = 4,
    localparam int NCH = NPORT * NVC,
    localparam int PW  = wbits(NPORT),
    localparam int VW  = wbits(NVC),
    localparam int OW  = wbits(NCH),
    localparam int CW  = wbits(CREDITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      in_valid,
    input  logic [NCH-1:0]      in_head,
    input  logic [NCH-1:0]      in_tail,
    input  logic [NCH*PW-1:0]   in_route,
    input  logic [NCH-1:0]      in_wrap,
    input  logic [NCH-1:0]      credit_ret,
    output logic [NCH-1:0]      in_pop,
    output logic [NPORT-1:0]    out_valid,
    output logic [NPORT*PW-1:0] out_src_port,
    output logic [NPORT*VW-1:0] out_src_vc,
    output logic [NPORT*VW-1:0] out_vc
);

    logic [NCH-1:0]          vc_req;
    logic [NCH-1:0]          vc_gnt;
    logic [NCH-1:0]          active;
    logic [NCH-1:0][PW-1:0]  tgt_port;
    logic [NCH-1:0][VW-1:0]  tgt_lvl;
    logic [NCH-1:0][OW-1:0]  ovc_a;
    logic [NCH-1:0]          cred_ok;
    logic [NCH-1:0]          sreq;
    logic [NCH-1:0]          sw_gnt;
    logic [NCH-1:0]          sent;
    logic [NCH-1:0]          rel;
    logic [NCH-1:0]          ovc_busy;
    logic [NCH-1:0][CW-1:0]  cred_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ivc
        vcsw_ivc_ctrl #(.NPORT(NPORT), .NVC(NVC), .LVL(i % NVC)) ctl_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .flit_valid(in_valid[i]),
            .flit_head (in_head[i]),
            .flit_tail (in_tail[i]),
            .route     (in_route[i*PW +: PW]),
            .wrap      (in_wrap[i]),
            .vc_gnt    (vc_gnt[i]),
            .sw_gnt    (sw_gnt[i]),
            .vc_req    (vc_req[i]),
            .active    (active[i]),
            .tgt_port  (tgt_port[i]),
            .tgt_lvl   (tgt_lvl[i])
        );
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            ovc_a[i]   = OW'(tgt_port[i]) * OW'(NVC) + OW'(tgt_lvl[i]);
            cred_ok[i] = (cred_q[ovc_a[i]] != '0);
            sreq[i]    = active[i] && in_valid[i] && cred_ok[i];
        end
    end

    vcsw_vc_alloc #(.NCH(NCH)) vca_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .vc_req     (vc_req),
        .req_ovc    (ovc_a),
        .release_ovc(rel),
        .vc_gnt     (vc_gnt),
        .busy       (ovc_busy)
    );

    vcsw_sw_alloc #(.NPORT(NPORT), .NVC(NVC)) swa_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sreq        (sreq),
        .req_port    (tgt_port),
        .req_lvl     (tgt_lvl),
        .sw_gnt      (sw_gnt),
        .out_valid   (out_valid),
        .out_src_port(out_src_port),
        .out_src_vc  (out_src_vc),
        .out_vc      (out_vc)
    );

    assign in_pop = sw_gnt;

    always_comb begin
        sent = '0;
        rel  = '0;
        for (int i = 0; i < NCH; i++) begin
            if (sw_gnt[i]) begin
                sent[ovc_a[i]] = 1'b1;
                if (in_tail[i]) begin
                    rel[ovc_a[i]] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int o = 0; o < NCH; o++) begin
                cred_q[o] <= CW'(CREDITS);
            end
        end else begin
            for (int o = 0; o < NCH; o++) begin
                if (sent[o] && !credit_ret[o]) begin
                    cred_q[o] <= cred_q[o] - 1'b1;
                end else if (!sent[o] && credit_ret[o]) begin
                    cred_q[o] <= cred_q[o] + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/vcsw_alloc_chk.sv
module vcsw_alloc_chk
    import vcsw_pkg::*;
#(
    parameter int NPORT   = 3,
    parameter int NVC     = 2,
    parameter int CREDITS = 4,
    localparam int NCH = NPORT * NVC,
    localparam int VW  = wbits(NVC),
    localparam int OW  = wbits(NCH),
    localparam int CW  = wbits(CREDITS + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCH-1:0]         in_valid,
    input logic [NCH-1:0]         in_pop,
    input logic [NPORT-1:0]       out_valid,
    input logic [NPORT*VW-1:0]    out_src_vc,
    input logic [NPORT*VW-1:0]    out_vc,
    input logic [NCH-1:0]         active,
    input logic [NCH-1:0][OW-1:0] ovc_a,
    input logic [NCH-1:0]         ovc_busy,
    input logic [NCH-1:0][CW-1:0] cred_q
);

    int owners [NCH];

    always_comb begin
        for (int o = 0; o < NCH; o++) begin
            owners[o] = 0;
            for (int i = 0; i < NCH; i++) begin
                if (active[i] && (int'(ovc_a[i]) == o)) begin
                    owners[o] = owners[o] + 1;
                end
            end
        end
    end

    // R9: every pop is reported on exactly one output port.
    a_r9_pop_matches_out: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_pop) == $countones(out_valid));

    for (genvar p = 0; p < NPORT; p++) begin : g_inp
        // R6: one flit per input port per cycle.
        a_r6_one_per_inport: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(in_pop[p*NVC +: NVC]));
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ich
        // R5: a grant needs a flit at the front of the buffer.
        a_r5_pop_needs_flit: assert property (@(posedge clk) disable iff (!rst_n)
            in_pop[i] |-> in_valid[i]);
    end

    for (genvar q = 0; q < NPORT; q++) begin : g_outp
        // R2: the dateline only ever raises the level.
        a_r2_level_not_lower: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[q] |-> (out_vc[q*VW +: VW] >= out_src_vc[q*VW +: VW]));
        // R5: a flit is sent only into a VC with room.
        a_r5_send_has_credit: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[q] |-> (cred_q[OW'(q * NVC) + OW'(out_vc[q*VW +: VW])] != '0));
    end

    for (genvar o = 0; o < NCH; o++) begin : g_och
        // R8: credits stay within the buffer depth.
        a_r8_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
            cred_q[o] <= CW'(CREDITS));
        // R3: at most one input VC holds an output VC.
        a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
            owners[o] <= 1);
        // R3: a held output VC is marked taken.
        a_r3_owner_marked: assert property (@(posedge clk) disable iff (!rst_n)
            (owners[o] != 0) |-> ovc_busy[o]);
    end

endmodule

bind vcsw_alloc vcsw_alloc_chk #(
    .NPORT  (NPORT),
    .NVC    (NVC),
    .CREDITS(CREDITS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_pop    (in_pop),
    .out_valid (out_valid),
    .out_src_vc(out_src_vc),
    .out_vc    (out_vc),
    .active    (active),
    .ovc_a     (ovc_a),
    .ovc_busy  (ovc_busy),
    .cred_q    (cred_q)
);

// File: tb/vcsw_alloc_tb_top.sv
module vcsw_alloc_tb_top;

    localparam int NPORT   = 3;
    localparam int NVC     = 2;
    localparam int CREDITS = 4;
    localparam int NCH     = NPORT * NVC;
    localparam int PW      = 2;
    localparam int VW      = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [NCH-1:0]      in_valid = '0, in_head = '0, in_tail = '0, in_wrap = '0, credit_ret = '0;
    logic [NCH*PW-1:0]   in_route = '0;
    logic [NCH-1:0]      in_pop;
    logic [NPORT-1:0]    out_valid;
    logic [NPORT*PW-1:0] out_src_port;
    logic [NPORT*VW-1:0] out_src_vc, out_vc;

    vcsw_alloc #(.NPORT(NPORT), .NVC(NVC), .CREDITS(CREDITS)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_head(in_head), .in_tail(in_tail),
        .in_route(in_route), .in_wrap(in_wrap), .credit_ret(credit_ret), .in_pop(in_pop),
        .out_valid(out_valid), .out_src_port(out_src_port), .out_src_vc(out_src_vc), .out_vc(out_vc)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Reference model state (behavioural)
    int m_st [NCH];
    int m_tgt [NCH];
    int m_busy [NCH];
    int m_cred [NCH];
    int m_vptr [NCH];
    int m_p1 [NPORT];
    int m_p2 [NPORT];

    // Traffic sources and downstream bookkeeping
    bit have [NCH];
    bit fhead [NCH];
    int remain [NCH];
    int frt [NCH];
    bit fwr [NCH];
    int owner_b [NCH];
    int outstanding [NCH];
    int max_out [NCH];
    int gen_pct = 0;
    bit ret_en = 1;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_st[i] = 0; m_tgt[i] = 0; m_busy[i] = 0; m_cred[i] = CREDITS; m_vptr[i] = 0;
            have[i] = 0; fhead[i] = 0; remain[i] = 0; frt[i] = 0; fwr[i] = 0;
            owner_b[i] = -1; outstanding[i] = 0; max_out[i] = 0;
        end
        for (int p = 0; p < NPORT; p++) begin
            m_p1[p] = 0; m_p2[p] = 0;
        end
    endtask

    task automatic step();
        int vg [NCH];
        int pop [NCH];
        int sel [NPORT];
        int e_ov [NPORT];
        int e_sp [NPORT];
        int e_sv [NPORT];
        int e_vc [NPORT];
        int cr [NCH];
        int snt [NCH];
        @(negedge clk);
        for (int i = 0; i < NCH; i++) begin
            if (!have[i] && $urandom_range(99, 0) < gen_pct) begin
                have[i] = 1; fhead[i] = 1;
                remain[i] = $urandom_range(4, 1);
                frt[i] = $urandom_range(NPORT - 1, 0);
                fwr[i] = ($urandom_range(3, 0) == 0);
            end
            in_valid[i] = have[i];
            in_head[i] = have[i] && fhead[i];
            in_tail[i] = have[i] && (remain[i] == 1);
            in_route[i*PW +: PW] = PW'(frt[i]);
            in_wrap[i] = fwr[i];
        end
        for (int o = 0; o < NCH; o++) begin
            cr[o] = (ret_en && outstanding[o] > 0 && $urandom_range(1, 0) == 1) ? 1 : 0;
            credit_ret[o] = cr[o][0];
        end
        #1;
        // VC allocation (per output VC, round-robin over input VCs)
        for (int i = 0; i < NCH; i++) begin vg[i] = 0; pop[i] = 0; snt[i] = 0; end
        for (int o = 0; o < NCH; o++) begin
            if (m_busy[o] == 0) begin
                for (int k = 0; k < NCH; k++) begin
                    int i;
                    i = (m_vptr[o] + k) % NCH;
                    if (m_st[i] == 1 && m_tgt[i] == o) begin
                        vg[i] = 1; m_vptr[o] = (i + 1) % NCH; break;
                    end
                end
            end
        end
        // Switch allocation, input stage
        for (int p = 0; p < NPORT; p++) begin
            sel[p] = -1;
            for (int k = 0; k < NVC; k++) begin
                int i;
                i = p * NVC + (m_p1[p] + k) % NVC;
                if (m_st[i] == 2 && in_valid[i] && m_cred[m_tgt[i]] > 0) begin
                    sel[p] = i; break;
                end
            end
        end
        // Switch allocation, output stage
        for (int q = 0; q < NPORT; q++) begin
            e_ov[q] = 0; e_sp[q] = 0; e_sv[q] = 0; e_vc[q] = 0;
            for (int k = 0; k < NPORT; k++) begin
                int p;
                p = (m_p2[q] + k) % NPORT;
                if (sel[p] >= 0 && m_tgt[sel[p]] / NVC == q) begin
                    e_ov[q] = 1; e_sp[q] = p; e_sv[q] = sel[p] % NVC; e_vc[q] = m_tgt[sel[p]] % NVC;
                    pop[sel[p]] = 1; snt[m_tgt[sel[p]]] = 1;
                    m_p2[q] = (p + 1) % NPORT;
                    m_p1[p] = (sel[p] % NVC + 1) % NVC;
                    break;
                end
            end
        end
        // Compare
        for (int i = 0; i < NCH; i++)
            chk(in_pop[i] == pop[i][0], "R4,R5,R6", $sformatf("in_pop[%0d]", i), int'(in_pop[i]), pop[i]);
        for (int q = 0; q < NPORT; q++) begin
            chk(out_valid[q] == e_ov[q][0], "R9", $sformatf("out_valid[%0d]", q), int'(out_valid[q]), e_ov[q]);
            if (e_ov[q] == 1 && out_valid[q]) begin
                chk(int'(out_src_port[q*PW +: PW]) == e_sp[q], "R7", $sformatf("out_src_port[%0d]", q),
                    int'(out_src_port[q*PW +: PW]), e_sp[q]);
                chk(int'(out_src_vc[q*VW +: VW]) == e_sv[q], "R7", $sformatf("out_src_vc[%0d]", q),
                    int'(out_src_vc[q*VW +: VW]), e_sv[q]);
                chk(int'(out_vc[q*VW +: VW]) == e_vc[q], "R2", $sformatf("out_vc[%0d]", q),
                    int'(out_vc[q*VW +: VW]), e_vc[q]);
            end
        end
        // Packet ownership of output VCs, seen at the ports (R3)
        for (int q = 0; q < NPORT; q++) begin
            if (out_valid[q]) begin
                int o, i;
                o = q * NVC + int'(out_vc[q*VW +: VW]);
                i = int'(out_src_port[q*PW +: PW]) * NVC + int'(out_src_vc[q*VW +: VW]);
                if (fhead[i]) begin
                    chk(owner_b[o] == -1, "R3", $sformatf("head on held ovc %0d", o), owner_b[o], -1);
                    owner_b[o] = i;
                end else begin
                    chk(owner_b[o] == i, "R3", $sformatf("body source on ovc %0d", o), i, owner_b[o]);
                end
                if (remain[i] == 1) owner_b[o] = -1;
                outstanding[o]++;
                if (outstanding[o] > max_out[o]) max_out[o] = outstanding[o];
            end
        end
        for (int o = 0; o < NCH; o++) outstanding[o] -= cr[o];
        // Advance sources by the design's grants
        for (int i = 0; i < NCH; i++) begin
            if (in_pop[i] && have[i]) begin
                if (remain[i] == 1) have[i] = 0;
                else begin remain[i]--; fhead[i] = 0; end
            end
        end
        // Model state update
        for (int i = 0; i < NCH; i++) begin
            if (m_st[i] == 0) begin
                if (in_valid[i] && in_head[i]) begin
                    int lv;
                    lv = i % NVC;
                    if (in_wrap[i] && lv < NVC - 1) lv = lv + 1;
                    m_st[i] = 1;
                    m_tgt[i] = int'(in_route[i*PW +: PW]) * NVC + lv;
                end
            end else if (m_st[i] == 1) begin
                if (vg[i] == 1) begin m_st[i] = 2; m_busy[m_tgt[i]] = 1; end
            end else begin
                if (pop[i] == 1 && in_tail[i]) begin m_st[i] = 0; m_busy[m_tgt[i]] = 0; end
            end
        end
        for (int o = 0; o < NCH; o++) m_cred[o] = m_cred[o] + cr[o] - snt[o];
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        bit full_seen;
        bit drained;
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset
        gen_pct = 0;
        repeat (3) step();
        chk(in_pop == '0, "R1", "in_pop after reset", int'(in_pop), 0);
        chk(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);
        // Random traffic with credit return
        gen_pct = 40; ret_en = 1;
        repeat (1500) step();
        // Credit starvation
        ret_en = 0;
        repeat (300) step();
        full_seen = 0;
        for (int o = 0; o < NCH; o++) if (max_out[o] == CREDITS) full_seen = 1;
        chk(full_seen, "R8", "some output VC used all credits", int'(full_seen), 1);
        // Resume and drain
        ret_en = 1;
        repeat (800) step();
        gen_pct = 0;
        repeat (300) step();
        for (int o = 0; o < NCH; o++)
            chk(max_out[o] <= CREDITS, "R8", $sformatf("in-flight on ovc %0d", o), max_out[o], CREDITS);
        drained = 1;
        for (int i = 0; i < NCH; i++) if (have[i]) drained = 0;
        chk(drained, "R3", "all packets completed and output VCs released", int'(drained), 1);
        for (int o = 0; o < NCH; o++)
            chk(owner_b[o] == -1, "R3", $sformatf("ovc %0d free at end", o), owner_b[o], -1);
        done = 1;
        summary();
        $finish;
    end

endmodule